// File: doc/BRIEF.md
# Flow-Controlled Byte Sink Buffer

This block sits on the peripheral side of a byte link. A producer pushes one 8-bit value per cycle with a write strobe. It may hold the strobe high on back-to-back cycles to send a burst. The block stores the bytes in a parameterised first-in first-out store. A local consumer drains them through a valid/ready handshake.

The block tells the producer when to stall through a registered full flag. The producer may sample that flag several cycles before it writes. For that reason the flag may rise only in the cycle after an accepted write that leaves every entry occupied. Nothing internal can raise it. A consumer pop may lower it at any time.

A write that arrives while the flag is high is discarded. It also sets a sticky overflow error. Only reset clears that error.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|-------|---------|
| `S_EMPTY` | No bytes stored. |
| `S_PART` | Between one and DEPTH-1 bytes stored. |
| `S_FULL` | DEPTH bytes stored; the full flag is the decode of this state. |

The machine makes these transitions:

| From | To | Condition |
|------|----|-----------|
| `S_EMPTY` | `S_PART` | An accepted write. |
| `S_PART` | `S_FULL` | A write without a pop while DEPTH-1 bytes are held. |
| `S_PART` | `S_EMPTY` | A pop without a write while one byte is held. |
| `S_FULL` | `S_PART` | A pop. |

Every other combination holds the current state. With DEPTH of 1, `S_EMPTY` and `S_FULL` step directly into each other.

Top module: `byte_sink_buf`

## Requirements
- R1: After reset the full flag is 0, the overflow error is 0 and `rd_valid_o` is 0.
- R2: Bytes leave on `rd_byte_o` in the order they were accepted. `rd_byte_o` shows the oldest stored byte whenever `rd_valid_o` is 1.
- R3: A burst with `wr_en_i` high on consecutive cycles stores one byte per cycle until the buffer is full.
- R4: In the cycle after an accepted write that brings occupancy to DEPTH (with no pop in that cycle), `full_o` is 1.
- R5: `full_o` rises only in the cycle after an accepted write. Idle cycles and pops never raise it.
- R6: When `full_o` is 1 and a pop occurs, `full_o` is 0 in the next cycle.
- R7: A write and a pop in the same cycle leave occupancy unchanged, so `full_o` does not rise in the next cycle.
- R8: A write while `full_o` is 1 is dropped. Its byte never appears on `rd_byte_o`, and `ovf_err_o` is 1 from the next cycle.
- R9: `ovf_err_o`, once set, stays 1 until reset.
- R10: A pop happens exactly when `rd_valid_o` and `rd_ready_i` are both 1. `rd_valid_o` is 1 exactly when occupancy is above zero, which starts from the cycle after the first accepted write into an empty buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Producer write strobe, one byte per high cycle |
| wr_byte_i | input | WIDTH | Producer byte |
| full_o | output | 1 | Registered full flag to the producer |
| ovf_err_o | output | 1 | Sticky error: a write arrived while full |
| rd_valid_o | output | 1 | A stored byte is available |
| rd_ready_i | input | 1 | Consumer accepts the byte this cycle |
| rd_byte_o | output | WIDTH | Oldest stored byte |

## Verification
A miscounted occupancy shows up first on `full_o`. The flag rises one write early or late, or it never drops after a pop, and this is visible in the very next cycle. A corrupted read or write pointer stays hidden until the affected entry reaches the head of the queue. It then surfaces as a wrong byte on `rd_byte_o`, at the latest DEPTH pops later. A lost or falsely set overflow bit is visible on `ovf_err_o` one cycle after the write that should or should not have set it, and the bit stays wrong from then on.

// File: rtl/byte_sink_pkg.sv
package byte_sink_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'b00,
        S_PART  = 2'b01,
        S_FULL  = 2'b10
    } occ_state_t;
endpackage

// File: rtl/byte_sink_store.sv
module byte_sink_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    assign dout = mem[rptr];

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr <= LAST) && (rptr <= LAST));
endmodule

// File: rtl/byte_sink_occ.sv
module byte_sink_occ
    import byte_sink_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic push,
    input  logic pop,
    output logic full,
    output logic valid,
    output logic ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] NEAR = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    occ_state_t     state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           ovf_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (push && !pop) cnt_nx = cnt + 1'b1;
        if (pop && !push) cnt_nx = cnt - 1'b1;
        unique case (state)
            S_EMPTY: if (push) state_nx = (DEPTH == 1) ? S_FULL : S_PART;
            S_PART: begin
                if (push && !pop && cnt == NEAR)      state_nx = S_FULL;
                else if (pop && !push && cnt == ONE)  state_nx = S_EMPTY;
            end
            S_FULL:  if (pop) state_nx = (DEPTH == 1) ? S_EMPTY : S_PART;
            default: state_nx = S_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_EMPTY;
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (wr_req && state == S_FULL) ovf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        full  = (state == S_FULL);
        valid = (state != S_EMPTY);
        ovf   = ovf_q;
    end

    // R4
    fill_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt == NEAR) |=> full);
    // R5
    full_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));
    // R7
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (cnt == $past(cnt)) && !$rose(full));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R10
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
    // R6
    pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop) |=> !full);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= TOP) && (full == (cnt == TOP)));
endmodule

// File: rtl/byte_sink_buf.sv
module byte_sink_buf #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_byte_i,
    output logic             full_o,
    output logic             ovf_err_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic [WIDTH-1:0] rd_byte_o
);
    logic push, pop, full, valid;

    assign push = wr_en_i && !full;
    assign pop  = valid && rd_ready_i;

    byte_sink_occ #(.DEPTH(DEPTH)) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_en_i),
        .push   (push),
        .pop    (pop),
        .full   (full),
        .valid  (valid),
        .ovf    (ovf_err_o)
    );

    byte_sink_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_byte_i),
        .dout  (rd_byte_o)
    );

    assign full_o     = full;
    assign rd_valid_o = valid;

    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && full_o) |=> ovf_err_o);
endmodule

// File: tb/byte_sink_buf_tb.sv
module byte_sink_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WIDTH = 8;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_ready = 0;
    logic [WIDTH-1:0] wr_byte = '0;
    logic full, ovf, valid;
    logic [WIDTH-1:0] rd_byte;

    int n_cmp = 0, n_bad = 0;

    logic [WIDTH-1:0] mq [DEPTH];
    int  mcnt = 0;
    bit  movf = 0;
    bit  prev_full = 0;
    bit  last_pp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_sink_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_byte_i(wr_byte),
        .full_o(full), .ovf_err_o(ovf), .rd_valid_o(valid),
        .rd_ready_i(rd_ready), .rd_byte_o(rd_byte)
    );

    function automatic bit exp_full(input int c);
        return c == DEPTH;
    endfunction

    function automatic bit exp_valid(input int c);
        return c > 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        bit ef;
        ef = exp_full(mcnt);
        if (last_pp)               chk("R7 full", full, ef);
        else if (ef && !prev_full) chk("R4 full", full, ef);
        else if (!ef && prev_full) chk("R6 full", full, ef);
        else                       chk("R5 full", full, ef);
        chk(movf ? "R9 ovf" : "R8 ovf", ovf, movf);
        chk("R10 valid", valid, exp_valid(mcnt));
        if (mcnt > 0) chk("R2 data", rd_byte, mq[0]);
    endtask

    task automatic model_step(input bit w, input logic [WIDTH-1:0] d, input bit r);
        bit mf, ps, pp;
        mf = exp_full(mcnt);
        ps = w && !mf;
        pp = r && (mcnt > 0);
        if (w && mf) movf = 1;
        prev_full = mf;
        last_pp = ps && pp;
        if (pp) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (ps) begin
            mq[mcnt] = d;
            mcnt++;
        end
    endtask

    task automatic cyc(input bit w, input logic [WIDTH-1:0] d, input bit r);
        check_outputs();
        wr_en = w; wr_byte = d; rd_ready = r;
        model_step(w, d, r);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_ready = 0;
        mcnt = 0; movf = 0; prev_full = 0; last_pp = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 full", full, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 valid", valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        @(negedge clk);
        do_reset();

        // R3: burst fill, one byte per cycle
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'h40 + 8'(i), 0);
        // R4 checked on this cycle; R8: write while full is dropped
        cyc(1, 8'hEE, 0);
        cyc(0, 8'h00, 0);
        // R5: idle while full, flag steady; then drain fully (R6, R2)
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 8'h00, 1);
        // R5: idle cycles after drain never raise full
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0);
        // R9: overflow remains set
        chk("R9 ovf held", ovf, 1);

        do_reset();
        // R7: fill to DEPTH-1, then push+pop together
        for (int i = 0; i < DEPTH - 1; i++) cyc(1, 8'h10 + 8'(i), 0);
        for (int i = 0; i < 4; i++) cyc(1, 8'h80 + 8'(i), 1);
        cyc(0, 8'h00, 0);
        chk("R7 not full", full, 0);
        // R10: ready without valid does nothing
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, 8'h00, 1);
        cyc(0, 8'h00, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit w, r;
            w = ($urandom % 100) < 55;
            r = ($urandom % 100) < 45;
            cyc(w, 8'($urandom), r);
        end
        cyc(0, 8'h00, 0);

        do_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule